// File: doc/BRIEF.md
# Two-Level Descriptor-Chain Copy Engine

This block is a single-channel memory-to-memory copy engine. Software starts it by writing one 32-bit start word. The engine then follows a chain of 32-bit pointer words. Each pointer names an array of 16-byte copy commands. The engine runs the commands one after another, finishes an array on the command that carries the end mark, and finishes the whole walk after the array whose pointer carried the chain-end mark. It then raises a single done pulse, or a single error pulse if it meets a command it cannot run.

Data moves in 64-bit beats. Each beat is read through a request/acknowledge read port and written back through a matching write port. Before it is written, the beat can have its bytes permuted: adjacent bytes, adjacent halfwords and the two 32-bit words can each be exchanged. Exchanges can be asked for on the source side, on the destination side, or on both. Either address can be held fixed for the whole copy instead of stepping by 8.

Top module: `dma_ptr_walker`

## Requirements
- R1: After reset, `ready_o` is 1, no read or write request is raised and no result pulse appears. `ready_o` is 1 only while the engine is idle, and while it is idle no request is raised.
- R2: A start word written while idle starts a walk only when bits 31:29 equal 1. The first pointer is then read at byte address {bits 28:0, 3'b000}. Any other value of bits 31:29 gives one error pulse, raises no read request and leaves the engine idle.
- R3: Pointer words lie 4 bytes apart. The pointer at byte address A is the upper half of the 64-bit beat at A with bits 2:0 cleared when A[2]=1, and the lower half otherwise. Bits 28:0 of a pointer give its array's byte address shifted right by 3. Bit 31 marks the last pointer. Bits 30:29 are ignored.
- R4: A command occupies 16 bytes. The first beat holds the command word in bits 31:0 and the source address in bits 63:32. The second beat holds the destination address in bits 31:0 and the byte length in bits 63:32. The commands of an array are consecutive.
- R5: After a command whose bit 31 is set, the engine reads the next pointer. If the current pointer was marked last, the walk ends instead.
- R6: A command whose bits 1:0 are not 0 ends the walk with one error pulse and moves no data for that command. Data moved by earlier commands remains.
- R7: A length with bits 2:0 not zero, or a source or destination address with bits 2:0 not zero, ends the walk with one error pulse and writes nothing for that command. A length of 0 moves no data, and the walk continues.
- R8: Each beat is read, then written. Let m = {b13^b16, b12^b15, b11^b14}, where bit 11 and bit 14 exchange bytes, bit 12 and bit 15 exchange halfwords, and bit 13 and bit 16 exchange words. Written byte i is then read byte i XOR m.
- R9: Command bit 17 keeps the source address fixed for every beat, and bit 18 does the same for the destination address. Otherwise each address steps by 8 per beat.
- R10: The end of a successful walk gives exactly one done pulse, and the engine is ready in that same cycle. Done and error pulses last one cycle and never occur together.
- R11: A start word written while the engine is busy is ignored. It pulses `cmd_drop_o` in the next cycle and does not change the walk in progress.
- R12: A request and its address (and its write data) stay unchanged until the request is acknowledged. Read and write requests are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cp_we_i | input | 1 | Start word write strobe |
| cp_data_i | input | 32 | Start word: mode in 31:29, list address >> 3 in 28:0 |
| ready_o | output | 1 | Engine idle |
| cmd_drop_o | output | 1 | Start word arrived while busy and was dropped |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address, 8-byte aligned |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 64 | Read beat |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write byte address, 8-byte aligned |
| wr_data_o | output | 64 | Write beat |
| wr_ack_i | input | 1 | Write acknowledge |
| rslt_done_o | output | 1 | Walk finished without error (pulse) |
| rslt_err_o | output | 1 | Walk ended on a bad start word or command (pulse) |

## Verification
The hardest situation to reach is a start word that arrives in the middle of a walk. Catching it needs a walk that is long enough, and a strobe placed a few cycles after the start, while the engine is still fetching or copying. The bench stretches one walk with a long copy and read/write latency. It then drives the second start word and checks that the dropped-command flag appears and that the walk's data and result stay unchanged. The permutation logic is swept over all 64 settings of the six exchange bits, with the hold bits cycling through the same runs. A three-pointer chain whose pointers straddle beat halves checks the two-level walk.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int DW      = 64;
  localparam int NB      = DW / 8;
  localparam int OFF_W   = $clog2(NB);
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 32;

  localparam int CP_MODE_LO    = 29;
  localparam int CP_MODE_PLIST = 1;
  localparam int LAST_BIT      = 31;
  localparam int SRC_HOLD_BIT  = 17;
  localparam int DST_HOLD_BIT  = 18;
  localparam int SRC_SWAP_LO   = 11;
  localparam int DST_SWAP_LO   = 14;

  typedef enum logic [2:0] {
    W_IDLE, W_PTR, W_CMD0, W_CMD1, W_CHECK, W_XFER
  } walk_state_e;

  typedef enum logic [1:0] {X_IDLE, X_RD, X_WR} xfer_state_e;
endpackage

// File: rtl/dmaw_swap.sv
module dmaw_swap
  import dmaw_pkg::*;
(
  input  logic [DW-1:0]    data_i,
  input  logic [OFF_W-1:0] mask_i,
  output logic [DW-1:0]    data_o
);
  // lane i takes lane i^mask: bit0 bytes, bit1 halfwords, bit2 words
  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [OFF_W-1:0] src_lane;
    assign src_lane = OFF_W'(i) ^ mask_i;
    assign data_o[8*i +: 8] = data_i[8*src_lane +: 8];
  end
endmodule

// File: rtl/dmaw_xfer.sv
module dmaw_xfer
  import dmaw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             src_hold_i,
  input  logic             dst_hold_i,
  input  logic [OFF_W-1:0] mask_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_ack_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic             wr_req_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  input  logic             wr_ack_i,
  output logic             done_o
);
  localparam int BEAT_W = LEN_W - OFF_W;

  xfer_state_e      state_q;
  logic [AW-1:0]    src_q, dst_q;
  logic             src_hold_q, dst_hold_q;
  logic [OFF_W-1:0] mask_q;
  logic [BEAT_W-1:0] beats_q;
  logic [DW-1:0]    buf_q, swapped;

  dmaw_swap u_swap (
    .data_i (rd_data_i),
    .mask_i (mask_q),
    .data_o (swapped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= X_IDLE;
      src_q      <= '0;
      dst_q      <= '0;
      src_hold_q <= 1'b0;
      dst_hold_q <= 1'b0;
      mask_q     <= '0;
      beats_q    <= '0;
      buf_q      <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        X_IDLE: if (start_i) begin
          src_q      <= src_i;
          dst_q      <= dst_i;
          src_hold_q <= src_hold_i;
          dst_hold_q <= dst_hold_i;
          mask_q     <= mask_i;
          beats_q    <= len_i[LEN_W-1:OFF_W];
          if (len_i[LEN_W-1:OFF_W] == '0) done_o <= 1'b1;
          else state_q <= X_RD;
        end
        X_RD: if (rd_ack_i) begin
          buf_q   <= swapped;
          state_q <= X_WR;
        end
        X_WR: if (wr_ack_i) begin
          if (!src_hold_q) src_q <= src_q + AW'(NB);
          if (!dst_hold_q) dst_q <= dst_q + AW'(NB);
          beats_q <= beats_q - 1'b1;
          if (beats_q == BEAT_W'(1)) begin
            done_o  <= 1'b1;
            state_q <= X_IDLE;
          end else begin
            state_q <= X_RD;
          end
        end
        default: state_q <= X_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q == X_RD);
  assign rd_addr_o = src_q;
  assign wr_req_o  = (state_q == X_WR);
  assign wr_addr_o = dst_q;
  assign wr_data_o = buf_q;
endmodule

// File: rtl/dma_ptr_walker.sv
module dma_ptr_walker
  import dmaw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cp_we_i,
  input  logic [31:0]   cp_data_i,
  output logic          ready_o,
  output logic          cmd_drop_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [63:0]   rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [63:0]   wr_data_o,
  input  logic          wr_ack_i,
  output logic          rslt_done_o,
  output logic          rslt_err_o
);
  walk_state_e       state_q;
  logic [AW-1:0]     ptr_addr_q, cmd_addr_q, src_q, dst_q;
  logic [WORD_W-1:0] cmd_q;
  logic [LEN_W-1:0]  len_q;
  logic              last_ptr_q;

  logic [WORD_W-1:0] ptr_word;
  logic              check_ok, x_start, x_done;
  logic              x_rd_req, x_wr_req;
  logic [AW-1:0]     x_rd_addr, x_wr_addr;
  logic [DW-1:0]     x_wr_data;
  logic [OFF_W-1:0]  swap_mask;
  logic              walk_rd;
  logic [AW-1:0]     walk_rd_addr;

  assign ptr_word  = ptr_addr_q[2] ? rd_data_i[63:32] : rd_data_i[31:0];
  assign swap_mask = cmd_q[SRC_SWAP_LO +: OFF_W] ^ cmd_q[DST_SWAP_LO +: OFF_W];
  assign check_ok  = (cmd_q[1:0] == 2'b00) && (len_q[OFF_W-1:0] == '0)
                  && (src_q[OFF_W-1:0] == '0) && (dst_q[OFF_W-1:0] == '0);
  assign x_start   = (state_q == W_CHECK) && check_ok;

  dmaw_xfer #(.AW(AW)) u_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (x_start),
    .src_i      (src_q),
    .dst_i      (dst_q),
    .len_i      (len_q),
    .src_hold_i (cmd_q[SRC_HOLD_BIT]),
    .dst_hold_i (cmd_q[DST_HOLD_BIT]),
    .mask_i     (swap_mask),
    .rd_req_o   (x_rd_req),
    .rd_addr_o  (x_rd_addr),
    .rd_ack_i   (rd_ack_i),
    .rd_data_i  (rd_data_i),
    .wr_req_o   (x_wr_req),
    .wr_addr_o  (x_wr_addr),
    .wr_data_o  (x_wr_data),
    .wr_ack_i   (wr_ack_i),
    .done_o     (x_done)
  );

  always_comb begin
    walk_rd      = 1'b1;
    walk_rd_addr = '0;
    unique case (state_q)
      W_PTR:   walk_rd_addr = {ptr_addr_q[AW-1:OFF_W], OFF_W'(0)};
      W_CMD0:  walk_rd_addr = cmd_addr_q;
      W_CMD1:  walk_rd_addr = cmd_addr_q + AW'(NB);
      default: walk_rd      = 1'b0;
    endcase
  end

  assign rd_req_o  = walk_rd | x_rd_req;
  assign rd_addr_o = walk_rd ? walk_rd_addr : x_rd_addr;
  assign wr_req_o  = x_wr_req;
  assign wr_addr_o = x_wr_addr;
  assign wr_data_o = x_wr_data;
  assign ready_o   = (state_q == W_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= W_IDLE;
      ptr_addr_q  <= '0;
      cmd_addr_q  <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      cmd_q       <= '0;
      len_q       <= '0;
      last_ptr_q  <= 1'b0;
      rslt_done_o <= 1'b0;
      rslt_err_o  <= 1'b0;
      cmd_drop_o  <= 1'b0;
    end else begin
      rslt_done_o <= 1'b0;
      rslt_err_o  <= 1'b0;
      cmd_drop_o  <= cp_we_i && (state_q != W_IDLE);
      unique case (state_q)
        W_IDLE: if (cp_we_i) begin
          if (cp_data_i[31:CP_MODE_LO] == 3'(CP_MODE_PLIST)) begin
            ptr_addr_q <= AW'({cp_data_i[28:0], 3'b000});
            state_q    <= W_PTR;
          end else begin
            rslt_err_o <= 1'b1;
          end
        end
        W_PTR: if (rd_ack_i) begin
          last_ptr_q <= ptr_word[LAST_BIT];
          cmd_addr_q <= AW'({ptr_word[28:0], 3'b000});
          ptr_addr_q <= ptr_addr_q + AW'(4);
          state_q    <= W_CMD0;
        end
        W_CMD0: if (rd_ack_i) begin
          cmd_q   <= rd_data_i[31:0];
          src_q   <= AW'(rd_data_i[63:32]);
          state_q <= W_CMD1;
        end
        W_CMD1: if (rd_ack_i) begin
          dst_q      <= AW'(rd_data_i[31:0]);
          len_q      <= rd_data_i[63:32];
          cmd_addr_q <= cmd_addr_q + AW'(2 * NB);
          state_q    <= W_CHECK;
        end
        W_CHECK: begin
          if (check_ok) begin
            state_q <= W_XFER;
          end else begin
            rslt_err_o <= 1'b1;
            state_q    <= W_IDLE;
          end
        end
        W_XFER: if (x_done) begin
          if (!cmd_q[LAST_BIT]) begin
            state_q <= W_CMD0;
          end else if (last_ptr_q) begin
            rslt_done_o <= 1'b1;
            state_q     <= W_IDLE;
          end else begin
            state_q <= W_PTR;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmaw_checker.sv
module dmaw_checker #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cp_we_i,
  input logic [31:0]   cp_data_i,
  input logic          ready_o,
  input logic          cmd_drop_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          wr_req_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [63:0]   wr_data_o,
  input logic          wr_ack_i,
  input logic          rslt_done_o,
  input logic          rslt_err_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!rd_req_o && !wr_req_o));

  assert_bad_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cp_we_i && cp_data_i[31:29] != 3'd1) |=> (rslt_err_o && ready_o));

  assert_result_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rslt_done_o, rslt_err_o}));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rslt_done_o |=> !rslt_done_o);

  assert_done_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rslt_done_o |-> ready_o);

  assert_busy_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_we_i && !ready_o) |=> cmd_drop_o);

  assert_rd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  assert_wr_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_port_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
endmodule

bind dma_ptr_walker dmaw_checker #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cp_we_i     (cp_we_i),
  .cp_data_i   (cp_data_i),
  .ready_o     (ready_o),
  .cmd_drop_o  (cmd_drop_o),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_ack_i    (rd_ack_i),
  .wr_req_o    (wr_req_o),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .wr_ack_i    (wr_ack_i),
  .rslt_done_o (rslt_done_o),
  .rslt_err_o  (rslt_err_o)
);

// File: tb/dma_ptr_walker_test.sv
module dma_ptr_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int MEM_WORDS = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cp_we = 1'b0;
  logic [31:0]   cp_data = '0;
  logic          ready, cmd_drop;
  logic          rd_req, rd_ack = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [63:0]   rd_data = '0;
  logic          wr_req, wr_ack = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [63:0]   wr_data;
  logic          rslt_done, rslt_err;

  logic [63:0] mem [MEM_WORDS];
  logic [63:0] exp_mem [MEM_WORDS];
  int lat = 0;
  int rd_wait = 0, wr_wait = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, err_cnt = 0;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_ptr_walker #(.AW(AW)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cp_we_i     (cp_we),
    .cp_data_i   (cp_data),
    .ready_o     (ready),
    .cmd_drop_o  (cmd_drop),
    .rd_req_o    (rd_req),
    .rd_addr_o   (rd_addr),
    .rd_ack_i    (rd_ack),
    .rd_data_i   (rd_data),
    .wr_req_o    (wr_req),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .wr_ack_i    (wr_ack),
    .rslt_done_o (rslt_done),
    .rslt_err_o  (rslt_err)
  );

  // memory model and result monitor, acting between edges
  initial begin
    forever begin
      @(negedge clk);
      rd_ack = 1'b0;
      wr_ack = 1'b0;
      if (rst_n) begin
        if (rd_req) begin
          if (rd_wait >= lat) begin
            rd_ack = 1'b1;
            rd_data = mem[rd_addr[11:3]];
            rd_wait = 0;
            rd_cnt++;
          end else rd_wait++;
        end else rd_wait = 0;
        if (wr_req) begin
          if (wr_wait >= lat) begin
            wr_ack = 1'b1;
            mem[wr_addr[11:3]] = wr_data;
            wr_wait = 0;
            wr_cnt++;
          end else wr_wait++;
        end else wr_wait = 0;
        if (rslt_done) done_cnt++;
        if (rslt_err) err_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = 8'(i * 7 + k * 29 + 3);
    return v;
  endfunction

  function automatic logic [63:0] swap64(input logic [63:0] d, input logic [2:0] m);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(i ^ int'(m)) +: 8];
    return r;
  endfunction

  task automatic init_mem();
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem[i] = (i >= 256) ? 64'h0 : pat(i);
      exp_mem[i] = mem[i];
    end
  endtask

  task automatic put32(input logic [31:0] a, input logic [31:0] v);
    if (a[2]) begin mem[a[11:3]][63:32] = v; exp_mem[a[11:3]][63:32] = v; end
    else      begin mem[a[11:3]][31:0]  = v; exp_mem[a[11:3]][31:0]  = v; end
  endtask

  task automatic put_cmd(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                         input logic [31:0] d, input logic [31:0] l);
    put32(a, c); put32(a + 4, s); put32(a + 8, d); put32(a + 12, l);
  endtask

  // expected effect of one valid command
  task automatic model_cmd(input logic [31:0] c, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] l);
    logic [2:0] m;
    m = c[13:11] ^ c[16:14];
    for (int b = 0; b < int'(l >> 3); b++) begin
      logic [31:0] sa, da;
      sa = c[17] ? s : s + 32'(8 * b);
      da = c[18] ? d : d + 32'(8 * b);
      exp_mem[da[11:3]] = swap64(exp_mem[sa[11:3]], m);
    end
  endtask

  task automatic start_walk(input logic [31:0] cp);
    @(negedge clk);
    cp_we = 1'b1; cp_data = cp;
    @(negedge clk);
    cp_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int c = 0; c < 20000 && !ready; c++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    logic [63:0] a = '0, e = '0;
    for (int i = 0; i < MEM_WORDS; i++) begin
      if (mem[i] !== exp_mem[i]) begin
        if (bad == 0) begin a = mem[i]; e = exp_mem[i]; end
        bad++;
      end
    end
    check(bad == 0, tag, a, e);
  endtask

  task automatic clear_cnt();
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; err_cnt = 0;
  endtask

  localparam logic [31:0] CP_PL = 32'h2000_0000;
  localparam logic [31:0] LASTB = 32'h8000_0000;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ready === 1'b1, "R1 ready after reset", 64'(ready), 64'd1);
    check(rd_req === 1'b0 && wr_req === 1'b0, "R1 no request after reset",
          64'({rd_req, wr_req}), 64'd0);
    check(rslt_done === 1'b0 && rslt_err === 1'b0, "R1 no result in reset",
          64'({rslt_done, rslt_err}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ready === 1'b1 && !rd_req, "R1 idle after release", 64'({ready, rd_req}), 64'd2);

    // R2: start words whose mode is not pointer-list
    for (int md = 0; md < 8; md++) begin
      if (md == 1) continue;
      clear_cnt();
      start_walk({3'(md), 29'h20});
      wait_idle();
      check(err_cnt == 1 && done_cnt == 0 && rd_cnt == 0, "R2 bad mode gives error only",
            64'({err_cnt[7:0], done_cnt[7:0], rd_cnt[7:0]}), 64'h010000);
    end

    // R8 R9 R4: sweep of all swap settings with hold combinations
    for (int sw = 0; sw < 64; sw++) begin
      logic [31:0] c, s;
      init_mem();
      c = LASTB | (32'(sw) << 11) | (32'(sw % 4) << 17);
      s = 32'h400 + 32'(8 * (sw % 8));
      put32(32'h000, LASTB | (32'h100 >> 3));
      put_cmd(32'h100, c, s, 32'h800, 32'd24);
      model_cmd(c, s, 32'h800, 32'd24);
      lat = sw % 3;
      clear_cnt();
      start_walk(CP_PL);
      wait_idle();
      check_mem($sformatf("R8 R9 swap/hold sweep data sw=%0d", sw));
      check(done_cnt == 1 && err_cnt == 0 && wr_cnt == 3, "R10 R4 sweep single done",
            64'({done_cnt[7:0], err_cnt[7:0], wr_cnt[7:0]}), 64'h010003);
    end

    // R3 R5 R7: three-pointer chain starting at an odd beat half
    begin
      init_mem();
      put32(32'h008, 32'h6000_0000 | (32'h100 >> 3));  // bits 30:29 set, ignored
      put32(32'h00C, 32'h180 >> 3);
      put32(32'h010, LASTB | (32'h200 >> 3));
      put_cmd(32'h100, 32'h0000_0800, 32'h400, 32'h800, 32'd16);
      put_cmd(32'h110, LASTB | 32'h0001_0000, 32'h440, 32'h880, 32'd8);
      put_cmd(32'h180, LASTB, 32'h480, 32'h900, 32'd0);
      put_cmd(32'h200, 32'h0000_1000, 32'h4C0, 32'h980, 32'd32);
      put_cmd(32'h210, 32'h0000_0000, 32'h500, 32'hA00, 32'd8);
      put_cmd(32'h220, LASTB | 32'h0000_4000, 32'h540, 32'hA80, 32'd16);
      model_cmd(32'h0000_0800, 32'h400, 32'h800, 32'd16);
      model_cmd(LASTB | 32'h0001_0000, 32'h440, 32'h880, 32'd8);
      model_cmd(32'h0000_1000, 32'h4C0, 32'h980, 32'd32);
      model_cmd(32'h0000_0000, 32'h500, 32'hA00, 32'd8);
      model_cmd(LASTB | 32'h0000_4000, 32'h540, 32'hA80, 32'd16);
      lat = 1;
      clear_cnt();
      start_walk(CP_PL | (32'h008 >> 3));
      wait_idle();
      check_mem("R3 R5 chain data");
      check(done_cnt == 1 && err_cnt == 0, "R5 chain one done",
            64'({done_cnt[7:0], err_cnt[7:0]}), 64'h0100);
      check(wr_cnt == 10, "R7 zero length moves nothing", 64'(wr_cnt), 64'd10);
      check(rd_cnt == 3 + 12 + 10, "R3 R4 fetch count", 64'(rd_cnt), 64'd25);
    end

    // R6: unsupported command mode after a good command
    begin
      init_mem();
      lat = 0;
      put32(32'h000, LASTB | (32'h100 >> 3));
      put_cmd(32'h100, 32'h0, 32'h400, 32'h800, 32'd16);
      put_cmd(32'h110, LASTB | 32'h2, 32'h440, 32'h880, 32'd16);
      model_cmd(32'h0, 32'h400, 32'h800, 32'd16);
      clear_cnt();
      start_walk(CP_PL);
      wait_idle();
      check(err_cnt == 1 && done_cnt == 0, "R6 bad command mode error",
            64'({err_cnt[7:0], done_cnt[7:0]}), 64'h0100);
      check_mem("R6 earlier data kept, none for bad command");
      check(wr_cnt == 2, "R6 write count", 64'(wr_cnt), 64'd2);
    end

    // R7: odd length and misaligned addresses
    for (int k = 0; k < 3; k++) begin
      logic [31:0] s, d, l;
      init_mem();
      s = (k == 1) ? 32'h404 : 32'h400;
      d = (k == 2) ? 32'h802 : 32'h800;
      l = (k == 0) ? 32'd12 : 32'd16;
      put32(32'h000, LASTB | (32'h100 >> 3));
      put_cmd(32'h100, LASTB, s, d, l);
      clear_cnt();
      start_walk(CP_PL);
      wait_idle();
      check(err_cnt == 1 && done_cnt == 0 && wr_cnt == 0, $sformatf("R7 alignment error case %0d", k),
            64'({err_cnt[7:0], done_cnt[7:0], wr_cnt[7:0]}), 64'h010000);
    end

    // R11: start word while busy is dropped
    begin
      init_mem();
      lat = 2;
      put32(32'h000, LASTB | (32'h100 >> 3));
      put_cmd(32'h100, LASTB | 32'h0000_2000, 32'h400, 32'h800, 32'd64);
      model_cmd(LASTB | 32'h0000_2000, 32'h400, 32'h800, 32'd64);
      clear_cnt();
      start_walk(CP_PL);
      repeat (4) @(negedge clk);
      check(ready === 1'b0, "R1 ready low while busy", 64'(ready), 64'd0);
      cp_we = 1'b1; cp_data = 32'h4000_0000;
      @(negedge clk);
      cp_we = 1'b0;
      check(cmd_drop === 1'b1, "R11 drop flag", 64'(cmd_drop), 64'd1);
      @(negedge clk);
      check(cmd_drop === 1'b0, "R11 drop flag single cycle", 64'(cmd_drop), 64'd0);
      wait_idle();
      check(done_cnt == 1 && err_cnt == 0, "R11 walk unaffected result",
            64'({done_cnt[7:0], err_cnt[7:0]}), 64'h0100);
      check_mem("R11 walk unaffected data");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule